// File: doc/BRIEF.md
# Multi-Context Reservation Monitor

This block tracks load-reserve / store-conditional reservations for several hardware thread contexts that share one memory. Each context has a request port with a valid strobe, a physical address and three qualifiers: write, locked and uncacheable. Each cycle the block accepts at most one request, picking the lowest-numbered context that is requesting. A locked read records a reservation for its context. A locked write is a conditional store, and the block decides whether it reaches memory. Any write that does reach memory cancels every reservation on the same 16-byte granule.

The response arrives one cycle after the request. It gives the context that was served, a commit bit (set when the access goes to memory, clear when it is suppressed) and a two-bit result code. Each context also keeps a count of its consecutive conditional-store failures. A one-cycle warning pulses each time that count reaches a nonzero multiple of a period, 100000 by default.

Top module: `resv_monitor`

## Requirements
- R1: At most one request is granted per cycle. The grant goes to the lowest-indexed context whose valid is high, and `req_grant` is a combinational one-hot vector in the request cycle.
- R2: A granted read with locked=1 stores its address as that context's reservation and marks the reservation live. A read with locked=0 changes no reservation. Every read responds with commit=1 and result=0.
- R3: Two addresses share a granule when they are equal after address bits [3:0] are ignored.
- R4: A cacheable locked write commits only if the issuer's reservation is live and in the same granule as the write. Its result is 1 if the reservation was live before the check and 0 otherwise, so a live reservation in a different granule gives result 1 with commit 0.
- R5: A failed conditional store responds with commit=0, clears the issuer's reservation and adds one to the issuer's consecutive-failure count.
- R6: A locked write with uncacheable=1 responds with commit=1 and result=2. It resets the issuer's failure count, and the issuer's own reservation does not decide whether it commits.
- R7: Every committed write clears the reservation of every context, the issuer included, whose reserved granule matches the write. This covers plain writes (which respond with commit=1 and result=0), successful conditional stores and uncacheable conditional stores.
- R8: A successful conditional store resets the issuer's failure count. `rsp_warn[i]` pulses with the response of the failure that brings context i's count to a nonzero multiple of FAIL_PERIOD.
- R9: Synchronous active-high reset makes every reservation dead, zeroes every failure count and zeroes all response outputs. Responses are registered, valid one cycle after the grant, and all zero after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NCTX | Request strobe per context |
| req_write | input | NCTX | 1 = write, 0 = read |
| req_locked | input | NCTX | Reserving read / conditional write |
| req_uncached | input | NCTX | Uncacheable qualifier |
| req_addr | input | NCTX*AW | Physical addresses, context i in bits [i*AW +: AW] |
| req_grant | output | NCTX | One-hot grant for this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_ctx | output | CW | Index of the served context |
| rsp_commit | output | 1 | 1 = access forwarded to memory |
| rsp_result | output | 2 | Result code |
| rsp_warn | output | NCTX | Failure-streak warning pulse per context |

## Verification
The properties assume that reset is high for at least one edge before any request, and that qualifiers on a context that is not requesting have no meaning. The bench never drives a request while reset is high. It draws addresses from a small pool whose entries share and straddle granules, so snoop clears and granule mismatches occur often. The bench runs with a short failure period so that the warning is reached well within the run.

// File: rtl/resv_pkg.sv
package resv_pkg;

    localparam int MAX_AW = 64;

    localparam logic [1:0] RES_NONE     = 2'd0;
    localparam logic [1:0] RES_UNCACHED = 2'd2;

    typedef struct packed {
        logic       commit;
        logic [1:0] result;
        logic       set_resv;
        logic       fail;
        logic       clr_cnt;
        logic       snoop;
    } verdict_t;

    function automatic logic same_granule(input logic [MAX_AW-1:0] a,
                                          input logic [MAX_AW-1:0] b,
                                          input int unsigned gbits);
        return (a >> gbits) == (b >> gbits);
    endfunction

endpackage

// File: rtl/resv_arbiter.sv
module resv_arbiter #(
    parameter int NCTX = 4,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic [NCTX-1:0] valid,
    output logic [NCTX-1:0] grant,
    output logic [CW-1:0]   idx,
    output logic            any
);
    assign grant[0] = valid[0];

    for (genvar i = 1; i < NCTX; i++) begin : g_pri
        assign grant[i] = valid[i] & ~(|valid[i-1:0]);
    end

    assign any = |valid;

    always_comb begin
        idx = '0;
        for (int i = NCTX - 1; i >= 0; i--) begin
            if (valid[i]) idx = CW'(i);
        end
    end
endmodule

// File: rtl/resv_decide.sv
module resv_decide
    import resv_pkg::*;
#(
    parameter int AW = 32,
    parameter int GBITS = 4
) (
    input  logic          valid,
    input  logic          write,
    input  logic          locked,
    input  logic          uncached,
    input  logic [AW-1:0] addr,
    input  logic          own_live,
    input  logic [AW-1:0] own_addr,
    output verdict_t      verdict
);
    logic hit;

    assign hit = same_granule(MAX_AW'(addr), MAX_AW'(own_addr), GBITS);

    always_comb begin
        verdict = '0;
        if (valid) begin
            if (!write) begin
                verdict.commit   = 1'b1;
                verdict.set_resv = locked;
            end else if (!locked) begin
                verdict.commit = 1'b1;
                verdict.snoop  = 1'b1;
            end else if (uncached) begin
                verdict.commit  = 1'b1;
                verdict.result  = RES_UNCACHED;
                verdict.clr_cnt = 1'b1;
                verdict.snoop   = 1'b1;
            end else begin
                verdict.result = {1'b0, own_live};
                if (own_live && hit) begin
                    verdict.commit  = 1'b1;
                    verdict.clr_cnt = 1'b1;
                    verdict.snoop   = 1'b1;
                end else begin
                    verdict.fail = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/resv_slot.sv
module resv_slot
    import resv_pkg::*;
#(
    parameter int AW = 32,
    parameter int GBITS = 4,
    parameter int FAIL_PERIOD = 100000,
    localparam int PW = $clog2(FAIL_PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [AW-1:0] set_addr,
    input  logic          fail_en,
    input  logic          clr_cnt,
    input  logic          snoop_en,
    input  logic [AW-1:0] snoop_addr,
    output logic          live,
    output logic [AW-1:0] resv_addr,
    output logic          warn_hit
);
    localparam logic [PW-1:0] LAST = PW'(FAIL_PERIOD - 1);

    logic [PW-1:0] phase;
    logic          snoop_hit;

    assign snoop_hit = snoop_en && live &&
                       same_granule(MAX_AW'(snoop_addr), MAX_AW'(resv_addr), GBITS);
    assign warn_hit  = fail_en && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            live      <= 1'b0;
            resv_addr <= '0;
        end else if (set_en) begin
            live      <= 1'b1;
            resv_addr <= set_addr;
        end else if (fail_en || snoop_hit) begin
            live <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_cnt) begin
            phase <= '0;
        end else if (fail_en) begin
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int NCTX = 4,
    parameter int AW = 32,
    parameter int GBITS = 4,
    parameter int FAIL_PERIOD = 100000,
    localparam int CW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCTX-1:0]   req_valid,
    input  logic [NCTX-1:0]   req_write,
    input  logic [NCTX-1:0]   req_locked,
    input  logic [NCTX-1:0]   req_uncached,
    input  logic [NCTX*AW-1:0] req_addr,
    output logic [NCTX-1:0]   req_grant,
    output logic              rsp_valid,
    output logic [CW-1:0]     rsp_ctx,
    output logic              rsp_commit,
    output logic [1:0]        rsp_result,
    output logic [NCTX-1:0]   rsp_warn
);
    logic [CW-1:0]   sel;
    logic            any;
    logic [AW-1:0]   sel_addr;
    logic [NCTX-1:0] live;
    logic [AW-1:0]   resv_addr [NCTX];
    logic [NCTX-1:0] warn_hit;
    verdict_t        verdict;

    resv_arbiter #(.NCTX(NCTX)) u_arb (
        .valid (req_valid),
        .grant (req_grant),
        .idx   (sel),
        .any   (any)
    );

    assign sel_addr = req_addr[sel*AW +: AW];

    resv_decide #(.AW(AW), .GBITS(GBITS)) u_dec (
        .valid    (any),
        .write    (req_write[sel]),
        .locked   (req_locked[sel]),
        .uncached (req_uncached[sel]),
        .addr     (sel_addr),
        .own_live (live[sel]),
        .own_addr (resv_addr[sel]),
        .verdict  (verdict)
    );

    for (genvar i = 0; i < NCTX; i++) begin : g_slot
        resv_slot #(.AW(AW), .GBITS(GBITS), .FAIL_PERIOD(FAIL_PERIOD)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .set_en     (req_grant[i] & verdict.set_resv),
            .set_addr   (sel_addr),
            .fail_en    (req_grant[i] & verdict.fail),
            .clr_cnt    (req_grant[i] & verdict.clr_cnt),
            .snoop_en   (verdict.snoop),
            .snoop_addr (sel_addr),
            .live       (live[i]),
            .resv_addr  (resv_addr[i]),
            .warn_hit   (warn_hit[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_ctx    <= '0;
            rsp_commit <= 1'b0;
            rsp_result <= RES_NONE;
            rsp_warn   <= '0;
        end else begin
            rsp_valid  <= any;
            rsp_ctx    <= any ? sel : '0;
            rsp_commit <= verdict.commit;
            rsp_result <= verdict.result;
            rsp_warn   <= warn_hit;
        end
    end
endmodule

// File: rtl/resv_monitor_checker.sv
module resv_monitor_checker #(
    parameter int NCTX = 4,
    parameter int CW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [NCTX-1:0] req_valid,
    input logic [NCTX-1:0] req_write,
    input logic [NCTX-1:0] req_locked,
    input logic [NCTX-1:0] req_uncached,
    input logic [NCTX-1:0] req_grant,
    input logic            rsp_valid,
    input logic [CW-1:0]   rsp_ctx,
    input logic            rsp_commit,
    input logic [1:0]      rsp_result,
    input logic [NCTX-1:0] rsp_warn
);
    logic g_read, g_plain_wr, g_unc_sc;

    assign g_read     = |(req_grant & ~req_write);
    assign g_plain_wr = |(req_grant & req_write & ~req_locked);
    assign g_unc_sc   = |(req_grant & req_write & req_locked & req_uncached);

    // R1
    a_r1_one_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_grant));
    a_r1_grant_needs_valid: assert property (@(posedge clk) disable iff (rst)
        (req_grant & ~req_valid) == '0);
    a_r1_lowest_first: assert property (@(posedge clk) disable iff (rst)
        req_valid[0] |-> req_grant[0]);
    // R2
    a_r2_read_commits: assert property (@(posedge clk) disable iff (rst)
        g_read |=> (rsp_commit && rsp_result == 2'd0));
    // R5
    a_r5_suppress_code: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_commit) |-> (rsp_result != 2'd2));
    // R6
    a_r6_uncached_code: assert property (@(posedge clk) disable iff (rst)
        g_unc_sc |=> (rsp_commit && rsp_result == 2'd2));
    // R7
    a_r7_plain_store: assert property (@(posedge clk) disable iff (rst)
        g_plain_wr |=> (rsp_commit && rsp_result == 2'd0));
    // R8
    a_r8_warn_on_fail: assert property (@(posedge clk) disable iff (rst)
        (|rsp_warn) |-> (rsp_valid && !rsp_commit));
    a_r8_warn_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_warn));
    // R9
    a_r9_resp_follows: assert property (@(posedge clk) disable iff (rst)
        (|req_valid) |=> rsp_valid);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(|req_valid) |=> (!rsp_valid && !rsp_commit && rsp_ctx == '0));
endmodule

bind resv_monitor resv_monitor_checker #(.NCTX(NCTX), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_locked   (req_locked),
    .req_uncached (req_uncached),
    .req_grant    (req_grant),
    .rsp_valid    (rsp_valid),
    .rsp_ctx      (rsp_ctx),
    .rsp_commit   (rsp_commit),
    .rsp_result   (rsp_result),
    .rsp_warn     (rsp_warn)
);

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
    localparam int NC  = 4;
    localparam int AW  = 32;
    localparam int PER = 7;
    localparam int CW  = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NC-1:0]      req_valid = '0, req_write = '0, req_locked = '0, req_uncached = '0;
    logic [NC*AW-1:0]   req_addr = '0;
    logic [NC-1:0]      req_grant;
    logic               rsp_valid, rsp_commit;
    logic [CW-1:0]      rsp_ctx;
    logic [1:0]         rsp_result;
    logic [NC-1:0]      rsp_warn;

    always #2.5 clk = ~clk;

    resv_monitor #(.NCTX(NC), .AW(AW), .GBITS(4), .FAIL_PERIOD(PER)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_locked(req_locked), .req_uncached(req_uncached), .req_addr(req_addr),
        .req_grant(req_grant), .rsp_valid(rsp_valid), .rsp_ctx(rsp_ctx),
        .rsp_commit(rsp_commit), .rsp_result(rsp_result), .rsp_warn(rsp_warn));

    // behavioural reference state
    bit            m_live [NC];
    int unsigned   m_addr [NC];
    int            m_fails [NC];
    // expectation for the response due at the next sample
    bit            e_valid, e_commit;
    int            e_ctx, e_result;
    bit [NC-1:0]   e_warn;
    string         e_tag;
    string         phase_tag = "R9";

    int errors = 0, checks = 0;
    bit done = 1'b0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s): actual=%0d expected=%0d at %0t", tag, phase_tag, act, exp, $time);
        end
    endtask

    function automatic bit gran_eq(int unsigned a, int unsigned b);
        return (a >> 4) == (b >> 4);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NC; i++) begin
            m_live[i] = 0; m_addr[i] = 0; m_fails[i] = 0;
        end
        e_valid = 0; e_commit = 0; e_ctx = 0; e_result = 0; e_warn = '0; e_tag = "R9";
    endtask

    // compute expectation and advance the model for the currently driven inputs
    task automatic model_step();
        int s;
        int unsigned a;
        s = -1;
        for (int i = NC - 1; i >= 0; i--) if (req_valid[i]) s = i;
        e_valid = 0; e_commit = 0; e_ctx = 0; e_result = 0; e_warn = '0; e_tag = "R9";
        if (s < 0) return;
        a = req_addr[s*AW +: AW];
        e_valid = 1; e_ctx = s;
        if (!req_write[s]) begin
            e_commit = 1; e_tag = "R2";
            if (req_locked[s]) begin m_live[s] = 1; m_addr[s] = a; end
        end else begin
            if (!req_locked[s]) begin
                e_commit = 1; e_tag = "R7";
            end else if (req_uncached[s]) begin
                e_commit = 1; e_result = 2; m_fails[s] = 0; e_tag = "R6";
            end else begin
                e_result = m_live[s];
                if (m_live[s] && gran_eq(m_addr[s], a)) begin
                    e_commit = 1; m_fails[s] = 0; e_tag = "R4";
                end else begin
                    e_tag = "R5";
                    m_live[s] = 0;
                    m_fails[s]++;
                    if (m_fails[s] % PER == 0) e_warn[s] = 1'b1;
                end
            end
            if (e_commit)
                for (int i = 0; i < NC; i++)
                    if (m_live[i] && gran_eq(m_addr[i], a)) m_live[i] = 0;
        end
    endtask

    task automatic compare_rsp();
        check({e_tag, " valid"},  rsp_valid,  e_valid);
        check({e_tag, " ctx"},    rsp_ctx,    e_ctx);
        check({e_tag, " commit"}, rsp_commit, e_commit);
        check({e_tag, " result"}, rsp_result, e_result);
        check("R8 warn",          rsp_warn,   e_warn);
    endtask

    // one cycle: compare the pending response, drive new inputs, check grant
    task automatic tick(bit [NC-1:0] v, bit [NC-1:0] w, bit [NC-1:0] l,
                        bit [NC-1:0] u, int unsigned a [NC]);
        bit [NC-1:0] eg;
        @(negedge clk);
        compare_rsp();
        req_valid = v; req_write = w; req_locked = l; req_uncached = u;
        for (int i = 0; i < NC; i++) req_addr[i*AW +: AW] = a[i];
        #1;
        eg = '0;
        for (int i = NC - 1; i >= 0; i--) if (v[i]) eg = bit'(1) << i;
        check("R1 grant", req_grant, eg);
        model_step();
    endtask

    task automatic one(int c, bit w, bit l, bit u, int unsigned addr);
        int unsigned a [NC];
        for (int i = 0; i < NC; i++) a[i] = 32'hDEAD_0000;
        a[c] = addr;
        tick(NC'(1) << c, NC'(w) << c, NC'(l) << c, NC'(u) << c, a);
    endtask

    task automatic idle();
        int unsigned a [NC];
        for (int i = 0; i < NC; i++) a[i] = 0;
        tick('0, '0, '0, '0, a);
    endtask

    initial begin : watchdog
        #(5 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R9: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int unsigned a [NC];
        model_reset();
        repeat (3) @(negedge clk);
        // R9: reset state of outputs
        check("R9 rst valid",  rsp_valid,  0);
        check("R9 rst commit", rsp_commit, 0);
        check("R9 rst result", rsp_result, 0);
        check("R9 rst warn",   rsp_warn,   0);
        rst = 1'b0;

        // R9: no reservation after reset -> conditional store fails
        phase_tag = "R9";
        one(0, 1, 1, 0, 32'h100);
        // R2 R3: reserve then store in same granule, different low bits
        phase_tag = "R3";
        one(1, 0, 1, 0, 32'h204);
        one(1, 1, 1, 0, 32'h20C);
        // R7: own committed store cleared the reservation
        phase_tag = "R7";
        one(1, 1, 1, 0, 32'h20C);
        // R4: live reservation, other granule -> result 1, suppressed
        phase_tag = "R4";
        one(2, 0, 1, 0, 32'h300);
        one(2, 1, 1, 0, 32'h310);
        one(2, 1, 1, 0, 32'h300);
        // R7: plain store clears other contexts' matching reservations
        phase_tag = "R7";
        one(0, 0, 1, 0, 32'h400);
        one(3, 0, 1, 0, 32'h408);
        one(2, 0, 1, 0, 32'h500);
        one(1, 1, 0, 0, 32'h40F);
        one(1, 1, 0, 0, 32'h510);
        one(0, 1, 1, 0, 32'h400);
        one(3, 1, 1, 0, 32'h408);
        one(2, 1, 1, 0, 32'h500);
        // R6: uncached conditional ignores reservation and keeps it
        phase_tag = "R6";
        one(2, 0, 1, 0, 32'h600);
        one(2, 1, 1, 1, 32'h700);
        one(2, 1, 1, 0, 32'h600);
        one(3, 1, 1, 1, 32'h900);
        // R2: plain read neither sets nor clears a reservation
        phase_tag = "R2";
        one(0, 0, 1, 0, 32'h800);
        one(0, 0, 0, 0, 32'h800);
        one(0, 1, 1, 0, 32'h800);
        one(1, 0, 0, 0, 32'hA00);
        one(1, 1, 1, 0, 32'hA00);
        // R1: simultaneous requests
        phase_tag = "R1";
        for (int i = 0; i < NC; i++) a[i] = 32'hB00 + i * 16;
        tick('1, '0, '1, '0, a);
        tick(4'b1110, '0, '0, '0, a);
        tick(4'b1100, 4'b1100, 4'b1100, '0, a);
        tick(4'b1000, '1, '1, '0, a);
        idle();
        // R8: streak of failures, warnings at multiples of the period
        phase_tag = "R8";
        for (int k = 0; k < 2 * PER + 1; k++) one(3, 1, 1, 0, 32'hC00);
        one(3, 1, 1, 1, 32'hC00);
        for (int k = 0; k < PER - 1; k++) one(3, 1, 1, 0, 32'hC00);
        one(3, 0, 1, 0, 32'hC00);
        one(3, 1, 1, 0, 32'hC04);
        for (int k = 0; k < PER; k++) one(3, 1, 1, 0, 32'hC00);
        idle();
        // mixed random traffic over a small overlapping address pool
        phase_tag = "R7";
        for (int n = 0; n < 4000; n++) begin
            bit [NC-1:0] v, w, l, u;
            for (int i = 0; i < NC; i++) begin
                v[i] = ($urandom % 3) == 0;
                w[i] = $urandom % 2;
                l[i] = ($urandom % 3) != 0;
                u[i] = ($urandom % 8) == 0;
                a[i] = 32'h1000 + ($urandom % 8) * 8 + ($urandom % 8);
            end
            tick(v, w, l, u, a);
        end
        idle();
        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule